// File: doc/BRIEF.md
# Dual Quadrature Position Counter

This block turns two incremental-encoder signal sets into position counts. Each channel has two phase lines, A and B, and an index line. All inputs are asynchronous. Each line passes through a synchronizer and an optional debounce filter. The two phase lines of a channel are then read as a two-bit Gray code `{A,B}`. Each legal single-bit step moves the channel's 16-bit count up or down by one.

A mode word controls the block. It can mask any of the eight legal step types individually, so that step is not counted. It can turn the debounce filter on, and it can join the two counters into one 32-bit counter. It can let the index line clear the count, and it can freeze the readable values while counting continues underneath. It also carries a master enable: when the enable is low, both counts are cleared and held at zero.

Software reaches the block through a small synchronous register port with three word addresses:
- address 0: the mode word;
- address 1: the readable value of channel 0;
- address 2: the readable value of channel 1.

Top module: `quad_counter_pair`

## Requirements
- R1: After reset, reads at addresses 0, 1 and 2 all return 0.
- R2: A write to address 0 stores the mode word, which reads back with bits [7:6] forced to 0. Writes to addresses 1 and 2 leave the readable values unchanged. Mode bit layout: [15:8] step mask, [5] stored only, [4] filter, [3] join, [2] index enable, [1] hold, [0] enable.
- R3: With the enable bit set, each channel counts up on the steps `{A,B}` 00→01, 01→11, 11→10 and 10→00. It counts down on the reverse steps.
- R4: A step in which both phase lines change in the same sampled cycle leaves the count unchanged.
- R5: Mask bits 8 to 11 suppress the up-steps 00→01, 01→11, 11→10 and 10→00, in that order. Mask bits 12 to 15 suppress the down-steps 01→00, 11→01, 10→11 and 00→10, in that order.
- R6: In independent mode, each 16-bit count wraps modulo 2^16 (0 minus 1 reads 0xFFFF).
- R7: With the join bit set, only channel 0's phase lines count, into a 32-bit value. Address 1 reads bits [15:0] and address 2 reads bits [31:16]. A carry or borrow out of the low half reaches the high half in the same cycle, and channel 1's phase lines have no effect.
- R8: With the index-enable bit set, a rising edge on a channel's (filtered) index line clears that channel's count. In joined mode, channel 0's index clears all 32 bits and channel 1's index has no effect. With the bit clear, index lines are ignored.
- R9: While the hold bit is set, the readable values stay at the count present when hold took effect, while counting continues. Clearing hold makes the live count readable again.
- R10: With the enable bit clear, both counts are zero and phase activity does not change them.
- R11: With the filter bit set, a level held for fewer than 4 system clocks after synchronization is ignored. With it clear, the same pulse is counted.
- R12: With the filter off, a phase change shows in the readable value after the third rising clock edge following it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on address) |
| phase_a | input | 2 | Phase A line per channel |
| phase_b | input | 2 | Phase B line per channel |
| index_in | input | 2 | Index line per channel |

## Verification
The assertions assume that every register write is a single-cycle strobe whose address and data are stable at the capturing edge. They also assume that a phase line does not toggle faster than the synchronizer can sample it. The stimulus changes inputs only on falling clock edges. It moves phase lines at most one step per group of several clocks, except in the deliberate double-jump and short-glitch cases. It pulses index lines for several clocks at a time. This keeps every transition visible to the decoder exactly once.

// File: rtl/qc_pkg.sv
package qc_pkg;

  localparam int QC_W = 16;

  typedef struct packed {
    logic [7:0] step_mask;
    logic [1:0] spare;
    logic       diff_sel;
    logic       filt_en;
    logic       join_en;
    logic       idx_en;
    logic       hold;
    logic       run;
  } mode_t;

  localparam logic [QC_W-1:0] MODE_WMASK = 16'hFF3F;

endpackage

// File: rtl/qc_input_cond.sv
module qc_input_cond #(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_en,
  input  logic din,
  output logic dout
);

  localparam int RUN_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl;
  logic                   filt_q, filt_d;
  logic [RUN_W-1:0]       run_q, run_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  assign lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    filt_d = filt_q;
    run_d  = '0;
    if (!filt_en) begin
      filt_d = lvl;
    end else if (lvl != filt_q) begin
      if (run_q == RUN_LAST) filt_d = lvl;
      else                   run_d  = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else begin
      filt_q <= filt_d;
      run_q  <= run_d;
    end
  end

  assign dout = filt_en ? filt_q : lvl;

  // R11
  filt_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && run_q != RUN_LAST) |=> $stable(filt_q));

endmodule

// File: rtl/qc_decoder.sv
module qc_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab,
  input  logic       idx,
  input  logic [7:0] mask,
  output logic       inc,
  output logic       dec,
  output logic       idx_rise
);

  logic [1:0] prev_ab;
  logic       prev_idx;
  logic [3:0] fwd, rev;
  logic [7:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ab  <= 2'b00;
      prev_idx <= 1'b0;
    end else begin
      prev_ab  <= ab;
      prev_idx <= idx;
    end
  end

  always_comb begin
    fwd = '0;
    rev = '0;
    case ({prev_ab, ab})
      4'b0001: fwd[0] = 1'b1;
      4'b0111: fwd[1] = 1'b1;
      4'b1110: fwd[2] = 1'b1;
      4'b1000: fwd[3] = 1'b1;
      4'b0100: rev[0] = 1'b1;
      4'b1101: rev[1] = 1'b1;
      4'b1011: rev[2] = 1'b1;
      4'b0010: rev[3] = 1'b1;
      default: ;
    endcase
  end

  assign hit      = {rev, fwd} & ~mask;
  assign inc      = |hit[3:0];
  assign dec      = |hit[7:4];
  assign idx_rise = idx & ~prev_idx;

  // R4
  no_double_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((prev_ab ^ ab) == 2'b11) |-> !(inc || dec));

endmodule

// File: rtl/qc_count_core.sv
module qc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  join_en,
  input  logic                  idx_en,
  input  logic [1:0]            inc,
  input  logic [1:0]            dec,
  input  logic [1:0]            idx_rise,
  output logic [1:0][CNT_W-1:0] cnt_next
);

  localparam int WIDE_W = 2 * CNT_W;

  logic [1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic [WIDE_W-1:0]     wide_d;
  logic                  cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    wide_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (join_en) begin
      if (idx_en && idx_rise[0]) wide_d = '0;
      else if (inc[0])           wide_d = cnt_q + 1'b1;
      else if (dec[0])           wide_d = cnt_q - 1'b1;
      cnt_d = wide_d;
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        if (idx_en && idx_rise[ch]) cnt_d[ch] = '0;
        else if (inc[ch])           cnt_d[ch] = cnt_q[ch] + 1'b1;
        else if (dec[ch])           cnt_d[ch] = cnt_q[ch] - 1'b1;
      end
    end
  end

  assign cnt_ce = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_next = cnt_d;

  // R10
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R8
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && idx_en && !join_en && idx_rise[0]) |=> (cnt_q[0] == '0));

  // R7
  join_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && join_en && !(idx_en && idx_rise[0]) && inc[0] && (cnt_q[0] == '1))
      |=> (cnt_q[0] == '0) && (cnt_q[1] == $past(cnt_q[1]) + 1'b1));

  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !join_en && !(idx_en && idx_rise[1]) && !inc[1] && !dec[1])
      |=> $stable(cnt_q[1]));

endmodule

// File: rtl/quad_counter_pair.sv
module quad_counter_pair
  import qc_pkg::*;
#(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [QC_W-1:0]   reg_wdata,
  output logic [QC_W-1:0]   reg_rdata,
  input  logic [1:0]        phase_a,
  input  logic [1:0]        phase_b,
  input  logic [1:0]        index_in
);

  localparam int NCH = 2;
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_VAL0 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VAL1 = ADDR_W'(2);

  logic [1:0] rst_pipe;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  mode_t mode_q, mode_d;
  logic  mode_ce;

  assign mode_ce = reg_wr && (reg_addr == A_MODE);

  always_comb begin
    mode_d = mode_q;
    if (mode_ce) mode_d = mode_t'(reg_wdata & MODE_WMASK);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)       mode_q <= '0;
    else if (mode_ce) mode_q <= mode_d;
  end

  logic [NCH-1:0] fa, fb, fi, inc, dec, irise;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    qc_input_cond #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)) u_ca (
      .clk(clk), .rst_n(rst_l), .filt_en(mode_q.filt_en),
      .din(phase_a[ch]), .dout(fa[ch]));
    qc_input_cond #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)) u_cb (
      .clk(clk), .rst_n(rst_l), .filt_en(mode_q.filt_en),
      .din(phase_b[ch]), .dout(fb[ch]));
    qc_input_cond #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)) u_ci (
      .clk(clk), .rst_n(rst_l), .filt_en(mode_q.filt_en),
      .din(index_in[ch]), .dout(fi[ch]));
    qc_decoder u_dec (
      .clk(clk), .rst_n(rst_l), .ab({fa[ch], fb[ch]}), .idx(fi[ch]),
      .mask(mode_q.step_mask), .inc(inc[ch]), .dec(dec[ch]),
      .idx_rise(irise[ch]));
  end

  logic [NCH-1:0][QC_W-1:0] cnt_next;

  qc_count_core #(.CNT_W(QC_W)) u_core (
    .clk(clk), .rst_n(rst_l), .run(mode_q.run), .join_en(mode_q.join_en),
    .idx_en(mode_q.idx_en), .inc(inc), .dec(dec), .idx_rise(irise),
    .cnt_next(cnt_next));

  logic [NCH-1:0][QC_W-1:0] view_q;
  logic                     view_ce;

  assign view_ce = !mode_q.hold;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)       view_q <= '0;
    else if (view_ce) view_q <= cnt_next;
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_VAL0:  reg_rdata = view_q[0];
      A_VAL1:  reg_rdata = view_q[1];
      default: reg_rdata = '0;
    endcase
  end

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_l)
    $past(mode_q.hold) |-> $stable(view_q));

  // R2
  spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (reg_addr == A_MODE) |-> (reg_rdata[7:6] == 2'b00));

endmodule

// File: tb/tb_quad_counter_pair.sv
module tb_quad_counter_pair;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [1:0]  phase_a, phase_b, index_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [1:0] cur [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_counter_pair dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phase_a(phase_a),
    .phase_b(phase_b), .index_in(index_in));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic expect_vals(input string req, input logic [15:0] e0, input logic [15:0] e1);
    logic [15:0] v;
    rd(2'd1, v); check(req, v, e0);
    rd(2'd2, v); check(req, v, e1);
  endtask

  task automatic set_ab(input int ch, input logic [1:0] code, input int gap);
    @(negedge clk);
    phase_a[ch] = code[1];
    phase_b[ch] = code[0];
    cur[ch] = code;
    repeat (gap) @(negedge clk);
  endtask

  function automatic logic [1:0] nxt(input logic [1:0] c, input bit up);
    logic [1:0] f, r;
    case (c)
      2'b00: begin f = 2'b01; r = 2'b10; end
      2'b01: begin f = 2'b11; r = 2'b00; end
      2'b11: begin f = 2'b10; r = 2'b01; end
      default: begin f = 2'b00; r = 2'b11; end
    endcase
    return up ? f : r;
  endfunction

  task automatic move(input int ch, input int n, input bit up, input int gap);
    for (int i = 0; i < n; i++) set_ab(ch, nxt(cur[ch], up), gap);
  endtask

  task automatic pulse_idx(input int ch);
    @(negedge clk); index_in[ch] = 1'b1;
    repeat (10) @(negedge clk);
    index_in[ch] = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd0, v); check("R1 mode", v, 16'h0000);
    expect_vals("R1 values", 16'h0000, 16'h0000);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); check("R2 readback", v, 16'hFF3F);
    wr(2'd1, 16'h1234);
    wr(2'd2, 16'h5678);
    expect_vals("R2 value write ignored", 16'h0000, 16'h0000);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_count;
    wr(2'd0, 16'h0001);
    move(0, 5, 1, 4);
    move(1, 3, 0, 4);
    expect_vals("R3/R6 up and wrap", 16'h0005, 16'hFFFD);
    move(0, 2, 0, 4);
    expect_vals("R3 down", 16'h0003, 16'hFFFD);
  endtask

  task automatic t_latency;
    logic [15:0] v;
    @(negedge clk);
    cur[0] = nxt(cur[0], 1);
    phase_a[0] = cur[0][1]; phase_b[0] = cur[0][0];
    repeat (2) @(posedge clk);
    @(negedge clk); rd(2'd1, v); check("R12 not after 2 edges", v, 16'h0003);
    @(posedge clk);
    @(negedge clk); rd(2'd1, v); check("R12 after 3 edges", v, 16'h0004);
  endtask

  task automatic t_illegal;
    set_ab(0, cur[0] ^ 2'b11, 6);
    expect_vals("R4 double jump", 16'h0004, 16'hFFFD);
  endtask

  task automatic t_mask;
    wr(2'd0, 16'h0000);
    expect_vals("R10 clear", 16'h0000, 16'h0000);
    set_ab(0, 2'b00, 4);
    wr(2'd0, 16'h0101);
    move(0, 4, 1, 4);
    expect_vals("R5 mask 00->01", 16'h0003, 16'h0000);
    wr(2'd0, 16'h8001);
    move(0, 4, 0, 4);
    expect_vals("R5 mask 00->10", 16'h0000, 16'h0000);
  endtask

  task automatic t_join;
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0009);
    move(0, 1, 0, 4);
    expect_vals("R7 borrow", 16'hFFFF, 16'hFFFF);
    move(0, 2, 1, 4);
    expect_vals("R7 carry", 16'h0001, 16'h0000);
    move(1, 3, 1, 4);
    expect_vals("R7 channel 1 ignored", 16'h0001, 16'h0000);
  endtask

  task automatic t_index;
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0005);
    move(0, 3, 1, 4);
    move(1, 2, 1, 4);
    pulse_idx(0);
    expect_vals("R8 index clears own channel", 16'h0000, 16'h0002);
    wr(2'd0, 16'h0001);
    move(0, 1, 1, 4);
    pulse_idx(0);
    expect_vals("R8 index disabled", 16'h0001, 16'h0002);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h000D);
    move(0, 1, 0, 4);
    pulse_idx(1);
    expect_vals("R8 joined ch1 index ignored", 16'hFFFF, 16'hFFFF);
    pulse_idx(0);
    expect_vals("R8 joined ch0 index clears", 16'h0000, 16'h0000);
  endtask

  task automatic t_hold;
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0001);
    move(0, 2, 1, 4);
    wr(2'd0, 16'h0003);
    move(0, 3, 1, 4);
    expect_vals("R9 frozen", 16'h0002, 16'h0000);
    wr(2'd0, 16'h0001);
    expect_vals("R9 released", 16'h0005, 16'h0000);
  endtask

  task automatic t_enable;
    wr(2'd0, 16'h0000);
    expect_vals("R10 disabled clear", 16'h0000, 16'h0000);
    move(0, 2, 1, 4);
    move(1, 2, 0, 4);
    expect_vals("R10 held at zero", 16'h0000, 16'h0000);
  endtask

  task automatic t_filter;
    set_ab(0, 2'b00, 6);
    wr(2'd0, 16'h1011);
    set_ab(0, 2'b01, 2);
    set_ab(0, 2'b00, 12);
    expect_vals("R11 filtered glitch", 16'h0000, 16'h0000);
    wr(2'd0, 16'h1001);
    set_ab(0, 2'b01, 2);
    set_ab(0, 2'b00, 12);
    expect_vals("R11 unfiltered glitch", 16'h0001, 16'h0000);
    wr(2'd0, 16'h1011);
    set_ab(0, 2'b01, 12);
    expect_vals("R11 filtered long step", 16'h0002, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    phase_a = '0; phase_b = '0; index_in = '0;
    cur[0] = 2'b00; cur[1] = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regs;
    t_count;
    t_latency;
    t_illegal;
    t_mask;
    t_join;
    t_index;
    t_hold;
    t_enable;
    t_filter;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule